// File: doc/BRIEF.md
# Machine-Mode Trap and Return Unit

This block keeps the machine-level trap state of a small in-order core. When the pipeline reports an exception, the block does all of the following in one clock edge. It stores the faulting PC, the cause code and the trap value. It pushes the interrupt-enable bit and the active privilege level onto a one-deep stack. It clears interrupts and switches to machine mode. It issues a redirect to the trap vector. A machine-return request undoes that stack operation in one edge and redirects to the saved exception PC.

Software reaches the six trap registers through a simple CSR port: a select code, a write strobe, write data, and a read-data bus that is always driven. Trap and return requests are single-cycle strobes. The block accepts them in every cycle, so there is no back-pressure and no ready signal on any pin. The redirect output is a one-cycle valid pulse that the fetch stage must consume in the cycle it appears. CSR select codes: 0 exception PC, 1 cause, 2 trap value, 3 vector base, 4 scratch, 5 status. In the status word, bit 0 is the interrupt enable, bit 1 is the saved enable, and bits 3:2 are the saved privilege. Privilege encodings: 0 user, 1 supervisor, 3 machine.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, `priv_o` is 3 (machine), `mie_o` is 0, `redirect_valid_o` is 0, and every CSR select code reads 0.
- R2: A trap request sets three registers, visible in the cycle after the request. Exception PC (code 0) holds `trap_pc_i`. Cause (code 1) holds `trap_cause_i`, zero-extended; a misaligned load uses code 4. Trap value (code 2) holds `trap_val_i`; for a misaligned load this is the faulting address.
- R3: In the cycle after a trap, four status changes are all visible together. Status bits 3:2 hold the `cur_priv_i` of the trap cycle. Status bit 1 holds the interrupt enable from before the trap. `mie_o` (status bit 0) is 0. `priv_o` is 3.
- R4: In the cycle after a trap or return request, `redirect_valid_o` is 1 for exactly one cycle. After a trap, `redirect_pc_o` is the vector base. In cycles with no request, `redirect_valid_o` is 0.
- R5: In the cycle after a return request, four results are visible. `redirect_pc_o` is the saved exception PC. `mie_o` equals the saved enable. `priv_o` equals the saved privilege. The status word then holds saved enable = 1 and saved privilege = 0 (the lowest mode).
- R6: When a trap and a return are requested in the same cycle, only the trap takes effect.
- R7: The vector base (code 3) always reads with bits 1:0 equal to zero, whatever value was written.
- R8: A read of the scratch register (code 4) returns its value from before any write applied in the same cycle. Written data appears from the next cycle on, so one access swaps the old and new values.
- R9: A CSR write to the exception PC, cause, trap value or status register in the same cycle as a trap or return is dropped.
- R10: Select codes 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | Trap entry strobe |
| trap_cause_i | input | CAUSE_W | Cause code of the trap |
| trap_pc_i | input | XLEN | PC of the faulting instruction |
| trap_val_i | input | XLEN | Exception-specific value |
| mret_req_i | input | 1 | Machine-return strobe |
| cur_priv_i | input | 2 | Privilege level active in the current cycle |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | CSR select code |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the current select code |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target PC |
| priv_o | output | 2 | Privilege level after trap handling |
| mie_o | output | 1 | Global interrupt enable |

## Verification
Every state change from a trap, return or CSR write lands on the edge that samples the request. So the redirect pulse, the privilege and the enable, and the CSR read-back are all due one cycle after the stimulus. The read bus is combinational on the current state, so it also reflects the update one cycle after the stimulus. The bench drives on the falling edge, waits exactly one rising edge, and samples on the next falling edge. At that point it checks the pulse and every affected register together, then checks one cycle later that the pulse has dropped. The scratch swap is checked before the edge, in the same cycle as the write.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int NUM_REGS = 5;

  typedef enum logic [2:0] {
    SEL_EPC     = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_TVAL    = 3'd2,
    SEL_TVEC    = 3'd3,
    SEL_SCRATCH = 3'd4,
    SEL_STATUS  = 3'd5
  } csr_sel_e;

  typedef struct packed {
    logic [1:0] spp;   // saved privilege
    logic       spie;  // saved interrupt enable
    logic       ie;    // live interrupt enable
  } stat_t;
endpackage

// File: rtl/mtrap_status.sv
`timescale 1ns/1ps
module mtrap_status
  import mtrap_pkg::*;
#(
  parameter logic [1:0] LOW_PRIV = PRIV_U
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_i,
  input  logic       leave_i,
  input  logic [1:0] cur_priv_i,
  input  logic       wr_i,
  input  stat_t      wdata_i,
  output stat_t      stat_o,
  output logic [1:0] priv_o
);
  stat_t      st_q;
  logic [1:0] priv_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= '0;
      priv_q <= PRIV_M;
    end else if (enter_i) begin
      st_q.spp  <= cur_priv_i;
      st_q.spie <= st_q.ie;
      st_q.ie   <= 1'b0;
      priv_q    <= PRIV_M;
    end else if (leave_i) begin
      st_q.ie   <= st_q.spie;
      st_q.spie <= 1'b1;
      st_q.spp  <= LOW_PRIV;
      priv_q    <= st_q.spp;
    end else if (wr_i) begin
      st_q <= wdata_i;
    end
  end

  assign stat_o = st_q;
  assign priv_o = priv_q;

  p_entry_stack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (stat_o.spie == $past(stat_o.ie)) && !stat_o.ie
                && (stat_o.spp == $past(cur_priv_i)) && (priv_o == PRIV_M));

  p_return_restore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_i && !enter_i) |=> (stat_o.ie == $past(stat_o.spie))
                && (priv_o == $past(stat_o.spp)) && stat_o.spie
                && (stat_o.spp == LOW_PRIV));
endmodule

// File: rtl/mtrap_regs.sv
`timescale 1ns/1ps
module mtrap_regs
  import mtrap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enter_i,
  input  logic                block_wr_i,
  input  logic [XLEN-1:0]     epc_d_i,
  input  logic [CAUSE_W-1:0]  cause_d_i,
  input  logic [XLEN-1:0]     tval_d_i,
  input  logic [NUM_REGS-1:0] wr_en_i,
  input  logic [XLEN-1:0]     wdata_i,
  output logic [XLEN-1:0]     q_o [NUM_REGS]
);
  localparam int NUM_CAP = 3;
  localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

  logic [XLEN-1:0] cap [NUM_CAP];
  assign cap[0] = epc_d_i;
  assign cap[1] = XLEN'(cause_d_i);
  assign cap[2] = tval_d_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [XLEN-1:0] r_q;
    if (i < NUM_CAP) begin : g_trapped
      always_ff @(posedge clk_i) begin
        if (!rst_ni)             r_q <= '0;
        else if (enter_i)        r_q <= cap[i];
        else if (wr_en_i[i] && !block_wr_i) r_q <= wdata_i;
      end
    end else begin : g_plain
      localparam logic [XLEN-1:0] WMASK = (i == int'(SEL_TVEC)) ? VEC_MASK : '1;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)         r_q <= '0;
        else if (wr_en_i[i]) r_q <= wdata_i & WMASK;
      end
    end
    assign q_o[i] = r_q;
  end

  p_vec_written_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[int'(SEL_TVEC)] |=> (q_o[int'(SEL_TVEC)][1:0] == 2'b00)
      && (q_o[int'(SEL_TVEC)][XLEN-1:2] == $past(wdata_i[XLEN-1:2])));

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (q_o[0] == $past(epc_d_i)) && (q_o[2] == $past(tval_d_i)));
endmodule

// File: rtl/mtrap_unit.sv
`timescale 1ns/1ps
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter int         CAUSE_W  = 5,
  parameter logic [1:0] LOW_PRIV = PRIV_U
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_req_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic [XLEN-1:0]    trap_val_i,
  input  logic               mret_req_i,
  input  logic [1:0]         cur_priv_i,
  input  logic               csr_we_i,
  input  logic [2:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         priv_o,
  output logic               mie_o
);
  logic                enter, leave, any_evt;
  logic [NUM_REGS-1:0] wr_en;
  logic                stat_wr;
  logic [XLEN-1:0]     regs_q [NUM_REGS];
  stat_t               stat_q;
  logic                rv_q;
  logic [XLEN-1:0]     rpc_q;

  // trap wins over return
  assign enter   = trap_req_i;
  assign leave   = mret_req_i & ~trap_req_i;
  assign any_evt = enter | leave;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    assign wr_en[k] = csr_we_i && (csr_sel_i == 3'(k));
  end
  assign stat_wr = csr_we_i && (csr_sel_i == SEL_STATUS);

  mtrap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (enter),
    .block_wr_i (leave),
    .epc_d_i    (trap_pc_i),
    .cause_d_i  (trap_cause_i),
    .tval_d_i   (trap_val_i),
    .wr_en_i    (wr_en),
    .wdata_i    (csr_wdata_i),
    .q_o        (regs_q)
  );

  mtrap_status #(.LOW_PRIV(LOW_PRIV)) status_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (enter),
    .leave_i    (leave),
    .cur_priv_i (cur_priv_i),
    .wr_i       (stat_wr),
    .wdata_i    (stat_t'(csr_wdata_i[3:0])),
    .stat_o     (stat_q),
    .priv_o     (priv_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
    end else begin
      rv_q <= any_evt;
      if (any_evt) rpc_q <= enter ? regs_q[int'(SEL_TVEC)] : regs_q[int'(SEL_EPC)];
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_sel_i)
      SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_TVEC, SEL_SCRATCH:
        csr_rdata_o = regs_q[csr_sel_i];
      SEL_STATUS:
        csr_rdata_o = XLEN'(stat_q);
      default:
        csr_rdata_o = '0;
    endcase
  end

  assign redirect_valid_o = rv_q;
  assign redirect_pc_o    = rpc_q;
  assign mie_o            = stat_q.ie;

  p_redirect_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i || mret_req_i) |=> redirect_valid_o);

  p_no_spurious_redirect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_req_i || mret_req_i) |=> !redirect_valid_o);

  p_trap_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && mret_req_i) |=> (priv_o == PRIV_M) && !mie_o
      && (redirect_pc_o == $past(regs_q[int'(SEL_TVEC)])));

  p_return_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_req_i && !trap_req_i) |=> (redirect_pc_o == $past(regs_q[int'(SEL_EPC)])));
endmodule

// File: tb/mtrap_unit_tb_top.sv
`timescale 1ns/1ps
module mtrap_unit_tb_top;
  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_req = 1'b0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic [XLEN-1:0] trap_val = '0;
  logic            mret_req = 1'b0;
  logic [1:0]      cur_priv = 2'b11;
  logic            csr_we = 1'b0;
  logic [2:0]      csr_sel = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            rv;
  logic [XLEN-1:0] rpc;
  logic [1:0]      priv;
  logic            mie;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  mtrap_unit #(.XLEN(XLEN), .CAUSE_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_req_i(trap_req), .trap_cause_i(trap_cause), .trap_pc_i(trap_pc),
    .trap_val_i(trap_val), .mret_req_i(mret_req), .cur_priv_i(cur_priv),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .redirect_valid_o(rv), .redirect_pc_o(rpc),
    .priv_o(priv), .mie_o(mie)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, input logic [XLEN-1:0] exp, input string req);
    csr_sel = sel;
    #0.5;
    chk(req, csr_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // drive one event cycle, return at the next falling edge (results due there)
  task automatic evt(input logic t, input logic m, input logic [CW-1:0] c,
                     input logic [XLEN-1:0] pc, input logic [XLEN-1:0] v, input logic [1:0] p);
    @(negedge clk);
    trap_req = t; mret_req = m; trap_cause = c; trap_pc = pc; trap_val = v; cur_priv = p;
    @(negedge clk);
    trap_req = 1'b0; mret_req = 1'b0; csr_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] pc_e, val_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 priv", XLEN'(priv), 32'd3);
    chk("R1 mie", XLEN'(mie), 32'd0);
    chk("R1 redirect", XLEN'(rv), 32'd0);
    for (int s = 0; s < 8; s++) rd(3'(s), 32'd0, "R1 csr");

    // R7 vector alignment
    wr(3'd3, 32'h0000_2003);
    rd(3'd3, 32'h0000_2000, "R7 vec");
    wr(3'd3, 32'h0000_1FFE);
    rd(3'd3, 32'h0000_1FFC, "R7 vec2");
    wr(3'd3, 32'h0000_2000);

    // R8 scratch swap
    wr(3'd4, 32'hA5A5_0001);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = 3'd4; csr_wdata = 32'h5A5A_0002;
    #0.5 chk("R8 old value", csr_rdata, 32'hA5A5_0001);
    @(negedge clk);
    csr_we = 1'b0;
    rd(3'd4, 32'h5A5A_0002, "R8 new value");

    // R10 unassigned codes
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, 32'd0, "R10 code6");
    rd(3'd7, 32'd0, "R10 code7");
    rd(3'd4, 32'h5A5A_0002, "R10 scratch kept");
    rd(3'd5, 32'd0, "R10 status kept");

    // R2-R5 sweep: privilege x enable x cause
    for (int pi = 0; pi < 3; pi++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int c = 0; c < 16; c++) begin
          logic [1:0] p;
          p = (pi == 2) ? 2'd3 : 2'(pi);
          pc_e  = 32'h8000_0000 + 32'((pi * 64 + ie * 32 + c) * 4);
          val_e = 32'hDEAD_0000 ^ 32'(c * 257);
          wr(3'd5, 32'(ie));
          evt(1'b1, 1'b0, CW'(c), pc_e, val_e, p);
          chk("R4 trap pulse", XLEN'(rv), 32'd1);
          chk("R4 trap target", rpc, 32'h0000_2000);
          chk("R3 mie cleared", XLEN'(mie), 32'd0);
          chk("R3 priv machine", XLEN'(priv), 32'd3);
          rd(3'd0, pc_e, "R2 epc");
          rd(3'd1, 32'(c), "R2 cause");
          rd(3'd2, val_e, "R2 tval");
          rd(3'd5, 32'((p << 2) | (ie << 1)), "R3 status");
          evt(1'b0, 1'b1, '0, '0, '0, 2'd3);
          chk("R5 return pulse", XLEN'(rv), 32'd1);
          chk("R5 return target", rpc, pc_e);
          chk("R5 mie restored", XLEN'(mie), 32'(ie));
          chk("R5 priv restored", XLEN'(priv), 32'(p));
          rd(3'd5, 32'((1 << 1) | ie), "R5 status");
          @(negedge clk);
          chk("R4 pulse one cycle", XLEN'(rv), 32'd0);
        end
      end
    end

    // R2 misaligned load: code 4 with faulting address
    evt(1'b1, 1'b0, CW'(4), 32'h0000_0400, 32'h0000_0803, 2'd0);
    rd(3'd1, 32'd4, "R2 misaligned cause");
    rd(3'd2, 32'h0000_0803, "R2 misaligned addr");

    // R6 trap and return together: trap wins
    wr(3'd5, 32'h0000_0001);
    evt(1'b1, 1'b1, CW'(2), 32'h0000_1234, 32'h0, 2'd1);
    chk("R6 target is vector", rpc, 32'h0000_2000);
    chk("R6 priv machine", XLEN'(priv), 32'd3);
    chk("R6 mie cleared", XLEN'(mie), 32'd0);
    rd(3'd0, 32'h0000_1234, "R6 epc");
    rd(3'd5, 32'h0000_0006, "R6 status");

    // R9 CSR write concurrent with trap is dropped
    @(negedge clk);
    trap_req = 1'b1; trap_cause = CW'(7); trap_pc = 32'h0000_4440; trap_val = 32'h1;
    cur_priv = 2'd0;
    csr_we = 1'b1; csr_sel = 3'd0; csr_wdata = 32'hFFFF_0000;
    @(negedge clk);
    trap_req = 1'b0; csr_we = 1'b0;
    rd(3'd0, 32'h0000_4440, "R9 epc kept trap pc");
    // R9 status write concurrent with return is dropped
    @(negedge clk);
    mret_req = 1'b1;
    csr_we = 1'b1; csr_sel = 3'd5; csr_wdata = 32'h0000_000F;
    @(negedge clk);
    mret_req = 1'b0; csr_we = 1'b0;
    rd(3'd5, 32'h0000_0002, "R9 status from return");
    chk("R9 priv from return", XLEN'(priv), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule